// File: doc/BRIEF.md
# Reset Hold Duration Meter

This block measures how long an asynchronous, active-low reset button line stays asserted. It counts cycles of the reference clock, nominally 25 MHz, so each count stands for 40 ns. A long press can then be told apart from a short one, for example to trigger a return to factory settings. One second corresponds to 25,000,000 counts. Software compares the value it reads against its own threshold. The distribution of the reset itself is handled elsewhere.

The button line passes through a synchronizer chain before it gates the counter. The counter only climbs while the synchronized line is low. It keeps its value when the line is released, so software can read it afterwards. If it reaches all ones it stays there.

Software reaches the single register through a valid/ready command channel and a valid/ready response channel:
- Every accepted command produces exactly one response.
- A command is accepted only when no response is waiting, or when the waiting response is being taken in the same cycle.
- A stalled response keeps its data unchanged until `rsp_ready` is high.

Writing a 1 to bit 31 clears the count.

Top module: `rst_hold_meter`

## Requirements
- R1: After `rst_n` is low, the count is zero, `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: `hold_n` passes through SYNC_STAGES (default 2) flops; a low level sampled on L consecutive rising edges adds exactly L to the count, and the result can be read from SYNC_STAGES+1 cycles after release.
- R3: While `hold_n` stays high, the count does not change.
- R4: Releasing `hold_n` keeps the count; a later low period continues from the kept value.
- R5: The count stops at 2^CNT_W-1 (CNT_W defaults to 29) and stays there while `hold_n` stays low.
- R6: An accepted write with `cmd_wdata[31]`=1 sets the count to zero; a write with bit 31 = 0 leaves it unchanged, and bits 30:0 of write data are ignored.
- R7: A clear and an increment on the same edge give zero, and counting resumes on the next edge.
- R8: A read response carries the count as it was on the accepting edge, in bits CNT_W-1:0, with bits 31:CNT_W zero; a write response carries all zeros, so bit 31 reads as zero.
- R9: A command is accepted when `cmd_valid` and `cmd_ready` are both high, and its response appears one cycle later. `cmd_ready` is high exactly when no response is pending or `rsp_ready` is high. A response held by `rsp_ready`=0 keeps `rsp_valid` and `rsp_rdata` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset of the block |
| hold_n | input | 1 | Asynchronous active-low button line being timed |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | 32 | Write data; bit 31 requests a clear |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read value, or zero for writes |

## Verification
A wrong count shows up as a mismatched read value on the first read after the fault, and never earlier, because the count is only visible through responses. Reads are placed after the synchronizer latency has settled, so an extra or missing flop in the chain shifts the result by a known number of counts. Faults that affect saturation or the clear priority leave a value that stays wrong on every read, until the next clear. A handshake fault either drops or duplicates a response in the scoreboard queue, or it changes the stalled data within one cycle.

// File: rtl/rhm_pkg.sv
package rhm_pkg;
  localparam int REG_W         = 32;
  localparam int CLR_BIT       = 31;
  localparam int TICKS_PER_SEC = 25_000_000;
endpackage

// File: rtl/rhm_sync.sv
module rhm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[LAST];
endmodule

// File: rtl/rhm_counter.sv
module rhm_counter #(
  parameter int W = 29
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_en,
  input  logic         clr,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic         at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (inc_en && !at_max) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rhm_regport.sv
module rhm_regport
  import rhm_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_we,
  input  logic [REG_W-1:0] cmd_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [REG_W-1:0] rsp_rdata,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clr_o
);
  logic             valid_q;
  logic [REG_W-1:0] data_q;
  logic             accept;
  logic             unused_wbits;

  assign unused_wbits = ^cmd_wdata[CLR_BIT-1:0];
  assign cmd_ready    = !valid_q || rsp_ready;
  assign accept       = cmd_valid && cmd_ready;
  assign clr_o        = accept && cmd_we && cmd_wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      data_q  <= cmd_we ? '0 : REG_W'(cnt_i);
    end else if (rsp_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_rdata = data_q;
endmodule

// File: rtl/rst_hold_meter.sv
module rst_hold_meter
  import rhm_pkg::*;
#(
  parameter int CNT_W       = 29,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_we,
  input  logic [REG_W-1:0] cmd_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [REG_W-1:0] rsp_rdata
);
  logic             hold_sync;
  logic             clr;
  logic [CNT_W-1:0] cnt_q;

  rhm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (hold_n),
    .sync_o  (hold_sync)
  );

  rhm_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_en (!hold_sync),
    .clr    (clr),
    .cnt_o  (cnt_q)
  );

  rhm_regport #(.CNT_W(CNT_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_we    (cmd_we),
    .cmd_wdata (cmd_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .cnt_i     (cnt_q),
    .clr_o     (clr)
  );
endmodule

// File: rtl/rhm_checks.sv
module rhm_checks #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_we,
  input logic             wr_clr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_rdata,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic clr_req;
  assign clr_req = cmd_valid && cmd_ready && cmd_we && wr_clr;

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> cnt == '0);

  assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !clr_req) |=> cnt == CMAX);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_req |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1)));

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_rdata[31:CNT_W] == '0);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata));

  assert_no_accept_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready);
endmodule

bind rst_hold_meter rhm_checks #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_we    (cmd_we),
  .wr_clr    (cmd_wdata[31]),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .cnt       (cnt_q)
);

// File: tb/sim_rst_hold_meter.sv
module sim_rst_hold_meter;
  localparam int W = 10;
  localparam logic [31:0] SAT = 32'((1 << W) - 1);
  localparam logic [31:0] CLR = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_n = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic rsp_ready = 1'b1;
  logic cmd_ready, rsp_valid;
  logic [31:0] rsp_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  rst_hold_meter #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic do_cmd(input logic we, input logic [31:0] wd,
                        input logic [31:0] exp, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_we = we; cmd_wdata = wd;
    push(exp, tag);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_we = 1'b0; cmd_wdata = '0;
  endtask

  task automatic press(input int len);
    @(negedge clk);
    hold_n = 1'b0;
    repeat (len) @(negedge clk);
    hold_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9: unexpected response actual %h expected none", rsp_rdata);
      end else begin
        check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R1 cmd_ready after reset", 32'(cmd_ready), 32'd1);
    do_cmd(1'b0, '0, 32'd0, "R1 count after reset");

    repeat (30) @(negedge clk);
    do_cmd(1'b0, '0, 32'd0, "R3 idle high no count");

    press(1);
    do_cmd(1'b0, '0, 32'd1, "R2 one-cycle press");
    do_cmd(1'b1, CLR, 32'd0, "R8 write response zero");
    do_cmd(1'b0, '0, 32'd0, "R6 clear to zero");

    press(7);
    do_cmd(1'b0, '0, 32'd7, "R2 seven-cycle press");
    repeat (20) @(negedge clk);
    do_cmd(1'b0, '0, 32'd7, "R4 held after release");
    press(5);
    do_cmd(1'b0, '0, 32'd12, "R4 continues from held");

    do_cmd(1'b1, 32'h7FFF_FFFF, 32'd0, "R8 write response zero");
    do_cmd(1'b0, '0, 32'd12, "R6 bit31 zero ignored");

    // R7: clear accepted on edge 10 of a 20-edge press -> 20+2-10 = 12
    do_cmd(1'b1, CLR, 32'd0, "R6 clear");
    @(negedge clk);
    hold_n = 1'b0;
    repeat (9) @(negedge clk);
    cmd_valid = 1'b1; cmd_we = 1'b1; cmd_wdata = CLR;
    push(32'd0, "R7 clear write response");
    @(negedge clk);
    cmd_valid = 1'b0; cmd_we = 1'b0; cmd_wdata = '0;
    repeat (10) @(negedge clk);
    hold_n = 1'b1;
    repeat (4) @(negedge clk);
    do_cmd(1'b0, '0, 32'd12, "R7 clear beats increment");

    do_cmd(1'b1, CLR, 32'd0, "R6 clear");
    press(1100);
    do_cmd(1'b0, '0, SAT, "R5 saturates");
    press(10);
    do_cmd(1'b0, '0, SAT, "R5 stays saturated");

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    do_cmd(1'b0, '0, SAT, "R9 stalled read");
    check("R9 valid while stalled", 32'(rsp_valid), 32'd1);
    check("R9 not ready while stalled", 32'(cmd_ready), 32'd0);
    repeat (2) @(negedge clk);
    check("R9 data stable while stalled", rsp_rdata, SAT);
    check("R9 valid still held", 32'(rsp_valid), 32'd1);
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 response drained", 32'(rsp_valid), 32'd0);
    check("R9 all responses seen", 32'(exp_q.size()), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule